// File: doc/BRIEF.md
# Link Configuration Fallback Selector

This block decides which link rate and lane count a link-training engine should try next. It holds a fixed list of nine configurations, sorted from the highest total bandwidth (per-lane rate times lanes) to the lowest. Because the list is sorted by total bandwidth, rate and lane count trade off against each other as the list is walked. Before it searches the list, the block limits the sink's advertised capabilities to what the transmitter can drive. The first configuration that fits both limits is offered. Each time training reports a failure, the block offers the next configuration that fits. When no fitting configuration is left, it reports failure.

A controller pulses `start` with the capability inputs valid. The block then raises `busy` and presents a rate code, a lane count and the two configuration bytes destined for the sink. The training engine answers with `train_pass` or `train_fail`. When the attempt sequence is over, `done` pulses for one cycle and `result` tells success from exhaustion. The training itself, sideband access and clock programming belong to other blocks.

Top module: `link_cfg_fallback`

## Requirements
- R1: While `rst` is high and after it, until the first `start`, `busy`, `done`, `result`, `rate_code`, `lane_cnt`, `cfg_byte0` and `cfg_byte1` are all zero.
- R2: A `start` seen while idle makes the block busy on the next cycle with the first fitting entry of this ordered list of (rate code, lanes): (0x14,4), (0x0a,4), (0x14,2), (0x06,4), (0x0a,2), (0x14,1), (0x06,2), (0x0a,1), (0x06,1). Rate codes 0x06, 0x0a and 0x14 mean 162000, 270000 and 540000 kB/s per lane, that is 27000 kB/s per code unit.
- R3: The lane limit is the smaller of `sink_lane_cap[4:0]` and `tx_lane_max`. The rate limit is the smaller of `sink_rate_cap` and `tx_rate_max`. Bits 7:5 of `sink_lane_cap` have no effect. All of these inputs, and `enh_frame_cap`, are captured at `start`.
- R4: An entry is skipped when its lane count is above the lane limit or its rate code is above the rate limit.
- R5: A `train_fail` while busy, without `train_pass`, presents the next fitting entry after the current one on the following cycle.
- R6: A `train_fail` when no later entry fits ends the attempt on the following cycle: `busy` is 0, `done` is 1 for exactly one cycle and `result` is 0. The configuration outputs keep the last entry tried.
- R7: A `train_pass` while busy ends the attempt on the following cycle with `busy` 0, `done` 1 and `result` 1, and the tried configuration is kept. `train_pass` wins over a simultaneous `train_fail`.
- R8: A `start` when no entry fits gives `done` 1 and `result` 0 on the next cycle. In that case `busy` stays 0 and the configuration outputs are unchanged.
- R9: `cfg_byte0` equals the rate code. `cfg_byte1` holds the lane count in bits 2:0, zeros in bits 6:3, and in bit 7 the captured `enh_frame_cap`.
- R10: While busy with neither `train_pass` nor `train_fail`, the block stays busy and all configuration outputs hold their values. In this state `start` and changes on the capability inputs have no effect.
- R11: While idle, `train_pass` and `train_fail` have no effect: `busy` and `done` stay 0. `result` keeps its last value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new attempt sequence (idle only) |
| train_pass | input | 1 | Current configuration trained successfully |
| train_fail | input | 1 | Current configuration failed to train |
| sink_lane_cap | input | 8 | Sink capability byte, lane count in bits 4:0 |
| sink_rate_cap | input | 8 | Sink maximum rate code |
| tx_lane_max | input | 5 | Transmitter maximum lane count |
| tx_rate_max | input | 8 | Transmitter maximum rate code |
| enh_frame_cap | input | 1 | Sink supports enhanced framing |
| busy | output | 1 | An attempt sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| result | output | 1 | 1 = trained, 0 = list exhausted; valid with `done` |
| rate_code | output | 8 | Rate code to try |
| lane_cnt | output | 3 | Lane count to try |
| cfg_byte0 | output | 8 | First sink configuration byte |
| cfg_byte1 | output | 8 | Second sink configuration byte |

## Verification
The properties assume that the training engine raises `train_pass` or `train_fail` only as single-cycle answers to an offered configuration. They also assume that `start` is asserted only to begin a sequence, although the block must ignore a `start` that arrives while it is busy. The stimulus drives both answer lines for exactly one cycle. It deliberately pulses them while idle, asserts them together, and toggles `start` and the capability inputs in the middle of an attempt, all to show that those cases leave the outputs alone. Capability values are chosen to include a zero lane limit, a limit of three lanes, a rate limit between two codes, and garbage in the upper capability bits.

// File: rtl/lcfs_pkg.sv
package lcfs_pkg;

    localparam int RATE_W     = 8;
    localparam int LANE_W     = 3;
    localparam int CAP_LANE_W = 5;
    localparam int NUM_CFG    = 9;
    localparam int IDX_W      = $clog2(NUM_CFG + 1);
    localparam int ENH_BIT    = 7;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [LANE_W-1:0] lanes;
    } link_cfg_t;

    typedef struct packed {
        logic [CAP_LANE_W-1:0] lanes;
        logic [RATE_W-1:0]     rate;
    } link_caps_t;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_TRY  = 1'b1
    } walk_state_t;

    // Ordered by total bandwidth, highest first; order is the fallback order.
    function automatic link_cfg_t cfg_entry(input logic [IDX_W-1:0] idx);
        link_cfg_t c;
        case (idx)
            4'd0:    c = '{rate: 8'h14, lanes: 3'd4};
            4'd1:    c = '{rate: 8'h0a, lanes: 3'd4};
            4'd2:    c = '{rate: 8'h14, lanes: 3'd2};
            4'd3:    c = '{rate: 8'h06, lanes: 3'd4};
            4'd4:    c = '{rate: 8'h0a, lanes: 3'd2};
            4'd5:    c = '{rate: 8'h14, lanes: 3'd1};
            4'd6:    c = '{rate: 8'h06, lanes: 3'd2};
            4'd7:    c = '{rate: 8'h0a, lanes: 3'd1};
            4'd8:    c = '{rate: 8'h06, lanes: 3'd1};
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic cfg_fits(input link_cfg_t c, input link_caps_t caps);
        logic lane_ok;
        logic rate_ok;
        lane_ok = {{(CAP_LANE_W-LANE_W){1'b0}}, c.lanes} <= caps.lanes;
        rate_ok = c.rate <= caps.rate;
        return lane_ok && rate_ok;
    endfunction

endpackage

// File: rtl/lcfs_cap_clamp.sv
module lcfs_cap_clamp
    import lcfs_pkg::*;
#(
    parameter int CAP_BYTE_W = 8
) (
    input  logic [CAP_BYTE_W-1:0] sink_lane_cap,
    input  logic [RATE_W-1:0]     sink_rate_cap,
    input  logic [CAP_LANE_W-1:0] tx_lane_max,
    input  logic [RATE_W-1:0]     tx_rate_max,
    output link_caps_t            caps
);
    localparam int HI_W = CAP_BYTE_W - CAP_LANE_W;

    logic [CAP_LANE_W-1:0] sink_lanes;
    logic [HI_W-1:0]       unused_cap_hi;

    assign sink_lanes    = sink_lane_cap[CAP_LANE_W-1:0];
    assign unused_cap_hi = sink_lane_cap[CAP_BYTE_W-1:CAP_LANE_W];

    always_comb begin
        caps.lanes = (sink_lanes > tx_lane_max) ? tx_lane_max : sink_lanes;
        caps.rate  = (sink_rate_cap > tx_rate_max) ? tx_rate_max : sink_rate_cap;
    end
endmodule

// File: rtl/lcfs_entry_finder.sv
module lcfs_entry_finder
    import lcfs_pkg::*;
#(
    parameter int N = NUM_CFG
) (
    input  link_caps_t       caps,
    input  logic [IDX_W-1:0] from_idx,
    output logic             found,
    output logic [IDX_W-1:0] sel_idx
);
    logic [N-1:0] cand;

    for (genvar g = 0; g < N; g++) begin : g_fit
        localparam logic [IDX_W-1:0] GI = IDX_W'(g);
        assign cand[g] = cfg_fits(cfg_entry(GI), caps) && (GI >= from_idx);
    end

    // Lowest candidate index wins: scan downward so the last hit is the lowest.
    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found   = 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lcfs_sink_fmt.sv
module lcfs_sink_fmt
    import lcfs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  link_cfg_t         cfg,
    input  logic              enh,
    output logic [BYTE_W-1:0] byte0,
    output logic [BYTE_W-1:0] byte1
);
    always_comb begin
        byte0               = BYTE_W'(cfg.rate);
        byte1               = '0;
        byte1[LANE_W-1:0]   = cfg.lanes;
        byte1[ENH_BIT]      = enh;
    end
endmodule

// File: rtl/lcfs_walker.sv
module lcfs_walker
    import lcfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             train_pass,
    input  logic             train_fail,
    input  link_caps_t       live_caps,
    input  logic             enh_in,
    input  logic             found,
    input  logic [IDX_W-1:0] sel_idx,
    output link_caps_t       search_caps,
    output logic [IDX_W-1:0] from_idx,
    output logic             busy,
    output logic             done,
    output logic             result,
    output link_cfg_t        cur_cfg,
    output logic             enh_q
);
    walk_state_t      state;
    logic [IDX_W-1:0] idx_q;
    link_caps_t       caps_q;

    // Idle: search the live inputs from the top; trying: search the latched
    // limits from the entry after the current one.
    assign search_caps = (state == WS_IDLE) ? live_caps : caps_q;
    assign from_idx    = (state == WS_IDLE) ? '0 : idx_q + 1'b1;
    assign busy        = (state == WS_TRY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WS_IDLE;
            idx_q   <= '0;
            caps_q  <= '0;
            enh_q   <= 1'b0;
            cur_cfg <= '0;
            done    <= 1'b0;
            result  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (start) begin
                        caps_q <= live_caps;
                        if (found) begin
                            state   <= WS_TRY;
                            idx_q   <= sel_idx;
                            cur_cfg <= cfg_entry(sel_idx);
                            enh_q   <= enh_in;
                        end else begin
                            done   <= 1'b1;
                            result <= 1'b0;
                        end
                    end
                end
                WS_TRY: begin
                    if (train_pass) begin
                        state  <= WS_IDLE;
                        done   <= 1'b1;
                        result <= 1'b1;
                    end else if (train_fail) begin
                        if (found) begin
                            idx_q   <= sel_idx;
                            cur_cfg <= cfg_entry(sel_idx);
                        end else begin
                            state  <= WS_IDLE;
                            done   <= 1'b1;
                            result <= 1'b0;
                        end
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/link_cfg_fallback.sv
module link_cfg_fallback
    import lcfs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  train_pass,
    input  logic                  train_fail,
    input  logic [7:0]            sink_lane_cap,
    input  logic [RATE_W-1:0]     sink_rate_cap,
    input  logic [CAP_LANE_W-1:0] tx_lane_max,
    input  logic [RATE_W-1:0]     tx_rate_max,
    input  logic                  enh_frame_cap,
    output logic                  busy,
    output logic                  done,
    output logic                  result,
    output logic [RATE_W-1:0]     rate_code,
    output logic [LANE_W-1:0]     lane_cnt,
    output logic [7:0]            cfg_byte0,
    output logic [7:0]            cfg_byte1
);
    link_caps_t       live_caps;
    link_caps_t       search_caps;
    logic [IDX_W-1:0] from_idx;
    logic [IDX_W-1:0] sel_idx;
    logic             found;
    link_cfg_t        cur_cfg;
    logic             enh_q;

    lcfs_cap_clamp #(.CAP_BYTE_W(8)) u_clamp (
        .sink_lane_cap (sink_lane_cap),
        .sink_rate_cap (sink_rate_cap),
        .tx_lane_max   (tx_lane_max),
        .tx_rate_max   (tx_rate_max),
        .caps          (live_caps)
    );

    lcfs_entry_finder #(.N(NUM_CFG)) u_find (
        .caps     (search_caps),
        .from_idx (from_idx),
        .found    (found),
        .sel_idx  (sel_idx)
    );

    lcfs_walker u_walk (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .train_pass  (train_pass),
        .train_fail  (train_fail),
        .live_caps   (live_caps),
        .enh_in      (enh_frame_cap),
        .found       (found),
        .sel_idx     (sel_idx),
        .search_caps (search_caps),
        .from_idx    (from_idx),
        .busy        (busy),
        .done        (done),
        .result      (result),
        .cur_cfg     (cur_cfg),
        .enh_q       (enh_q)
    );

    lcfs_sink_fmt #(.BYTE_W(8)) u_fmt (
        .cfg   (cur_cfg),
        .enh   (enh_q),
        .byte0 (cfg_byte0),
        .byte1 (cfg_byte1)
    );

    assign rate_code = cur_cfg.rate;
    assign lane_cnt  = cur_cfg.lanes;
endmodule

// File: rtl/lcfs_chk.sv
module lcfs_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       train_pass,
    input logic       train_fail,
    input logic       busy,
    input logic       done,
    input logic       result,
    input logic [7:0] rate_code,
    input logic [2:0] lane_cnt,
    input logic [7:0] cfg_byte1
);
    // R10: an attempt without an answer keeps everything in place
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !train_pass && !train_fail) |=>
            (busy && $stable(rate_code) && $stable(lane_cnt) && $stable(cfg_byte1)));

    // R7: a pass closes the sequence successfully
    p_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && train_pass) |=> (done && result && !busy));

    // R2: busy only ever begins on a start
    p_busy_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R2: an offered configuration is always a legal list entry
    p_legal_cfg_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($onehot(lane_cnt) && lane_cnt != 3'd0 &&
                  (rate_code == 8'h06 || rate_code == 8'h0a || rate_code == 8'h14)));

    // R6: done is a single pulse and never overlaps busy
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R11: idle without start stays quiet whatever the answer lines do
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> (!busy && !done));
endmodule

bind link_cfg_fallback lcfs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .train_pass (train_pass),
    .train_fail (train_fail),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .rate_code  (rate_code),
    .lane_cnt   (lane_cnt),
    .cfg_byte1  (cfg_byte1)
);

// File: tb/link_cfg_fallback_test.sv
module link_cfg_fallback_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       train_pass = 1'b0;
    logic       train_fail = 1'b0;
    logic [7:0] sink_lane_cap = 8'h00;
    logic [7:0] sink_rate_cap = 8'h00;
    logic [4:0] tx_lane_max = 5'd0;
    logic [7:0] tx_rate_max = 8'h00;
    logic       enh_frame_cap = 1'b0;
    logic       busy, done, result;
    logic [7:0] rate_code, cfg_byte0, cfg_byte1;
    logic [2:0] lane_cnt;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    link_cfg_fallback uut (
        .clk(clk), .rst(rst), .start(start),
        .train_pass(train_pass), .train_fail(train_fail),
        .sink_lane_cap(sink_lane_cap), .sink_rate_cap(sink_rate_cap),
        .tx_lane_max(tx_lane_max), .tx_rate_max(tx_rate_max),
        .enh_frame_cap(enh_frame_cap),
        .busy(busy), .done(done), .result(result),
        .rate_code(rate_code), .lane_cnt(lane_cnt),
        .cfg_byte0(cfg_byte0), .cfg_byte1(cfg_byte1)
    );

    // Reference list (rate code, lanes) by descending bandwidth
    int tab_rate [9] = '{20, 10, 20, 6, 10, 20, 6, 10, 6};
    int tab_lane [9] = '{4, 4, 2, 4, 2, 1, 2, 1, 1};

    // Behavioural model state
    int m_busy = 0, m_done = 0, m_result = 0;
    int m_rate = 0, m_lanes = 0, m_enh = 0, m_pos = 0;
    int m_cl = 0, m_cr = 0;

    function automatic int next_fit(int from, int cl, int cr);
        for (int k = from; k < 9; k++)
            if (tab_lane[k] <= cl && tab_rate[k] <= cr) return k;
        return 9;
    endfunction

    always @(posedge clk) begin
        int nd;
        int nx;
        if (rst) begin
            m_busy = 0; m_done = 0; m_result = 0;
            m_rate = 0; m_lanes = 0; m_enh = 0; m_pos = 0;
        end else begin
            nd = 0;
            if (m_busy == 0) begin
                if (start) begin
                    m_cl = int'(sink_lane_cap & 8'h1f);
                    if (m_cl > int'(tx_lane_max)) m_cl = int'(tx_lane_max);
                    m_cr = int'(sink_rate_cap);
                    if (m_cr > int'(tx_rate_max)) m_cr = int'(tx_rate_max);
                    nx = next_fit(0, m_cl, m_cr);
                    if (nx < 9) begin
                        m_busy = 1; m_pos = nx; m_enh = int'(enh_frame_cap);
                        m_rate = tab_rate[nx]; m_lanes = tab_lane[nx];
                    end else begin
                        nd = 1; m_result = 0;
                    end
                end
            end else if (train_pass) begin
                m_busy = 0; nd = 1; m_result = 1;
            end else if (train_fail) begin
                nx = next_fit(m_pos + 1, m_cl, m_cr);
                if (nx < 9) begin
                    m_pos = nx; m_rate = tab_rate[nx]; m_lanes = tab_lane[nx];
                end else begin
                    m_busy = 0; nd = 1; m_result = 0;
                end
            end
            m_done = nd;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2", "rate_code", int'(rate_code), m_rate);
            chk("R2", "lane_cnt", int'(lane_cnt), m_lanes);
            chk("R9", "cfg_byte0", int'(cfg_byte0), m_rate);
            chk("R9", "cfg_byte1", int'(cfg_byte1), m_lanes + 128 * m_enh);
            chk("R10", "busy", int'(busy), m_busy);
            chk("R6", "done", int'(done), m_done);
            chk("R7", "result", int'(result), m_result);
        end
    end

    task automatic set_caps(input int sl, input int sr, input int tl, input int tr, input int en);
        sink_lane_cap = 8'(sl); sink_rate_cap = 8'(sr);
        tx_lane_max = 5'(tl); tx_rate_max = 8'(tr); enh_frame_cap = 1'(en);
    endtask

    task automatic go();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic fail1();
        train_fail = 1'b1; @(negedge clk); train_fail = 1'b0;
    endtask

    task automatic pass1();
        train_pass = 1'b1; @(negedge clk); train_pass = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "result", int'(result), 0);
        chk("R1", "rate_code", int'(rate_code), 0);
        chk("R1", "cfg_byte1", int'(cfg_byte1), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "lane_cnt after release", int'(lane_cnt), 0);

        // Full capabilities, walk the whole list to exhaustion
        set_caps(8'h84, 8'h14, 4, 8'h14, 1);
        go();
        chk("R2", "first rate", int'(rate_code), 8'h14);
        chk("R2", "first lanes", int'(lane_cnt), 4);
        chk("R9", "byte0", int'(cfg_byte0), 8'h14);
        chk("R9", "byte1 with enh", int'(cfg_byte1), 8'h84);
        for (int k = 1; k < 9; k++) begin
            fail1();
            chk("R5", "next rate", int'(rate_code), tab_rate[k]);
            chk("R5", "next lanes", int'(lane_cnt), tab_lane[k]);
        end
        fail1();
        chk("R6", "busy after exhaust", int'(busy), 0);
        chk("R6", "done after exhaust", int'(done), 1);
        chk("R6", "result after exhaust", int'(result), 0);
        chk("R6", "rate kept", int'(rate_code), 8'h06);
        @(negedge clk);
        chk("R6", "done one cycle", int'(done), 0);

        // Clamped: sink junk upper bits, tx limits 2 lanes / 0x0a
        set_caps(8'he4, 8'h14, 2, 8'h0a, 0);
        go();
        chk("R3", "clamped rate", int'(rate_code), 8'h0a);
        chk("R3", "clamped lanes", int'(lane_cnt), 2);
        chk("R9", "byte1 no enh", int'(cfg_byte1), 8'h02);
        start = 1'b1;
        set_caps(8'h81, 8'h06, 1, 8'h06, 1);
        repeat (3) @(negedge clk);
        start = 1'b0;
        chk("R10", "held rate", int'(rate_code), 8'h0a);
        chk("R10", "held lanes", int'(lane_cnt), 2);
        chk("R10", "still busy", int'(busy), 1);
        fail1();
        chk("R4", "skip to rate", int'(rate_code), 8'h06);
        chk("R4", "skip to lanes", int'(lane_cnt), 2);
        pass1();
        chk("R7", "done on pass", int'(done), 1);
        chk("R7", "result on pass", int'(result), 1);
        chk("R7", "idle on pass", int'(busy), 0);
        chk("R7", "kept rate", int'(rate_code), 8'h06);

        // No entry fits
        set_caps(8'h00, 8'h14, 4, 8'h14, 1);
        go();
        chk("R8", "done no fit", int'(done), 1);
        chk("R8", "result no fit", int'(result), 0);
        chk("R8", "busy no fit", int'(busy), 0);
        chk("R8", "cfg unchanged", int'(cfg_byte1), 8'h02);

        // Answers while idle
        train_fail = 1'b1; train_pass = 1'b1;
        repeat (2) @(negedge clk);
        train_fail = 1'b0; train_pass = 1'b0;
        chk("R11", "done idle", int'(done), 0);
        chk("R11", "busy idle", int'(busy), 0);
        chk("R11", "result kept", int'(result), 0);

        // Pass and fail together
        set_caps(8'h04, 8'h14, 4, 8'h14, 0);
        go();
        train_fail = 1'b1; train_pass = 1'b1;
        @(negedge clk);
        train_fail = 1'b0; train_pass = 1'b0;
        chk("R7", "pass wins", int'(result), 1);
        chk("R7", "pass wins done", int'(done), 1);

        // Three-lane limit skips every four-lane entry
        set_caps(8'h03, 8'h14, 4, 8'h14, 0);
        go();
        chk("R4", "3 lanes rate", int'(rate_code), 8'h14);
        chk("R4", "3 lanes lanes", int'(lane_cnt), 2);
        fail1();
        chk("R4", "3 lanes second", int'(rate_code), 8'h0a);
        fail1();
        chk("R4", "3 lanes third lanes", int'(lane_cnt), 1);
        pass1();

        // Rate limit between codes
        set_caps(8'h04, 8'h08, 4, 8'h14, 1);
        go();
        chk("R4", "rate limit 0x08 rate", int'(rate_code), 8'h06);
        chk("R4", "rate limit 0x08 lanes", int'(lane_cnt), 4);
        pass1();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule